// File: doc/BRIEF.md
# Transfer Unit Size Search Engine

This block picks a transfer-unit (TU) size and a valid-symbol count for a packetised video link. A start pulse latches the pixel clock in kHz, the colour depth, a 4:2:2 flag, the lane count and the link rate in MHz. The engine then tries candidate TU sizes in turn. For each candidate it works out the valid-symbol count with integer arithmetic only. It accepts the first candidate whose count meets the fill constraints.

Every candidate passes through a single shared restoring divider twice. The first pass divides the scaled pixel payload by the link capacity. The second pass splits that quotient into a whole symbol count and a remainder in thousandths. Each candidate therefore costs the same fixed number of cycles.

When the search ends, the engine raises a one-cycle done pulse. It then shows either a packed configuration word or an error flag. Both results stay unchanged until the next accepted start.

Top module: `tu_fill_search`

## Requirements
- R1: Bits per pixel are twice the colour depth when the 4:2:2 flag is set, and three times the colour depth otherwise.
- R2: For a candidate TU, the engine takes q = floor(TU × pixel clock × bpp / (lanes × link rate × 8)). The symbol count is floor(q / 1000) and the fraction is q mod 1000.
- R3: On success, cfgWord[7:0] holds the symbol count, cfgWord[15:8] holds the TU size, and cfgWord[16] (counter-reset enable) is 1. All other bits are 0, and searchErr is 0.
- R4: The first candidate is TU = 32. Each rejection adds 2 to TU, and the first candidate that passes every check is reported.
- R5: A candidate is rejected when its symbol count is 1 or less, or when TU minus the symbol count is below 4 (this includes the case where the count exceeds TU).
- R6: A candidate is rejected when its fraction is below 100 or above 850. Fractions of exactly 100 and exactly 850 are accepted.
- R7: If the candidate TU = 64 is rejected, the search ends with done, searchErr = 1 and cfgWord = 0.
- R8: If the lane count or the link rate is zero, no division is performed. In that case done and searchErr = 1 appear two clock edges after the edge that samples start, and cfgWord = 0.
- R9: done lasts exactly one cycle, and busy is low while done is high. cfgWord and searchErr hold their values, whatever the inputs do, until the next accepted start.
- R10: A start pulse that arrives while busy is high is ignored. The running search completes with the result for the inputs it latched, and it gives a single done.
- R11: After reset, busy, done and searchErr are 0 and cfgWord is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse; latches the inputs when the engine is idle |
| pixClkKhz | input | PIX_W (20) | Pixel clock in kHz |
| colorDepth | input | DEPTH_W (5) | Bits per colour component |
| is422 | input | 1 | 1 selects 4:2:2 sampling |
| laneCount | input | LANE_W (3) | Number of active lanes |
| linkRateMhz | input | RATE_W (12) | Link symbol rate in MHz |
| busy | output | 1 | A search is in progress |
| done | output | 1 | One-cycle pulse when a result is posted |
| searchErr | output | 1 | No acceptable TU was found, or an argument was zero |
| cfgWord | output | WORD_W (32) | Packed symbol count, TU size and counter-reset enable |

## Verification
Two functions can meet in the same cycle: the intake of a fresh start pulse, and the progress or final commit of a search that is already running. The bench provokes this by pulsing start in the middle of a running search. The new inputs are chosen so that, had they been latched, they would give a very different result (a fast zero-lane error). The collision is judged at the ports: the posted word must match the bench's own model of the first job, only one done pulse may appear, and the result must not be overwritten in the cycles that follow.

// File: rtl/tu_search_pkg.sv
package tu_search_pkg;

  localparam int TU_FIRST = 32;
  localparam int TU_STEP  = 2;
  localparam int TU_LAST  = 64;
  localparam int TU_W     = 7;
  localparam int SCALE    = 1000;
  localparam int FRAC_W   = 10;
  localparam int FRAC_LO  = 100;
  localparam int FRAC_HI  = 850;
  localparam int TU_LSB   = 8;
  localparam int RST_BIT  = 16;

  typedef struct packed {
    logic latchIn;
    logic startDivA;
    logic startDivB;
    logic captureSym;
    logic stepTu;
    logic commitOk;
    logic commitErr;
  } ctrlStrobe_t;

  typedef struct packed {
    logic divDone;
    logic candOk;
    logic tuLast;
    logic argZero;
  } dpStatus_t;

endpackage

// File: rtl/tu_restoring_div.sv
module tu_restoring_div #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  localparam int CNT_W = $clog2(W + 1);

  logic [W-1:0]     quoR;
  logic [W-1:0]     remR;
  logic [W-1:0]     divR;
  logic [CNT_W-1:0] cnt;
  logic             running;
  logic             doneR;
  logic [W:0]       shifted;
  logic [W:0]       trial;

  assign shifted = {remR, quoR[W-1]};
  assign trial   = shifted - {1'b0, divR};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoR    <= '0;
      remR    <= '0;
      divR    <= '0;
      cnt     <= '0;
      running <= 1'b0;
      doneR   <= 1'b0;
    end else if (start) begin
      quoR    <= dividend;
      remR    <= '0;
      divR    <= divisor;
      cnt     <= CNT_W'(W);
      running <= 1'b1;
      doneR   <= 1'b0;
    end else if (running) begin
      if (!trial[W]) begin
        remR <= trial[W-1:0];
        quoR <= {quoR[W-2:0], 1'b1};
      end else begin
        remR <= shifted[W-1:0];
        quoR <= {quoR[W-2:0], 1'b0};
      end
      cnt <= cnt - CNT_W'(1);
      if (cnt == CNT_W'(1)) begin
        running <= 1'b0;
        doneR   <= 1'b1;
      end
    end else begin
      doneR <= 1'b0;
    end
  end

  assign quotient  = quoR;
  assign remainder = remR;
  assign done      = doneR;

endmodule

// File: rtl/tu_search_dp.sv
module tu_search_dp
  import tu_search_pkg::*;
#(
  parameter int PIX_W   = 20,
  parameter int DEPTH_W = 5,
  parameter int LANE_W  = 3,
  parameter int RATE_W  = 12,
  parameter int WORD_W  = 32
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobe_t         strobe,
  input  logic [PIX_W-1:0]    pixClkKhz,
  input  logic [DEPTH_W-1:0]  colorDepth,
  input  logic                is422,
  input  logic [LANE_W-1:0]   laneCount,
  input  logic [RATE_W-1:0]   linkRateMhz,
  output dpStatus_t           status,
  output logic                done,
  output logic                searchErr,
  output logic [WORD_W-1:0]   cfgWord
);
  localparam int BPP_W = DEPTH_W + 2;
  localparam int NUM_W = PIX_W + BPP_W + TU_W;
  localparam int DEN_W = LANE_W + RATE_W + 3;
  localparam int DIV_W = (NUM_W > DEN_W) ? NUM_W : DEN_W;

  logic [PIX_W-1:0]   pixR;
  logic [DEPTH_W-1:0] depthR;
  logic               is422R;
  logic [LANE_W-1:0]  lanesR;
  logic [RATE_W-1:0]  rateR;
  logic [TU_W-1:0]    tuR;
  logic [DIV_W-1:0]   symR;
  logic [FRAC_W-1:0]  fracR;

  logic [BPP_W-1:0]   bpp;
  logic [DIV_W-1:0]   product;
  logic [DIV_W-1:0]   linkCap;
  logic [DIV_W-1:0]   divNum;
  logic [DIV_W-1:0]   divDen;
  logic [DIV_W-1:0]   divQuo;
  logic [DIV_W-1:0]   divRem;
  logic               divStart;
  logic               divDone;

  // Sample-size rule: two components per pixel for 4:2:2, three otherwise
  assign bpp = is422R ? BPP_W'({depthR, 1'b0})
                      : BPP_W'(depthR) * BPP_W'(3);

  assign product = DIV_W'(tuR) * DIV_W'(pixR) * DIV_W'(bpp);
  assign linkCap = (DIV_W'(lanesR) * DIV_W'(rateR)) << 3;

  // Pass A: payload over link capacity; pass B: split into whole and thousandths
  assign divStart = strobe.startDivA | strobe.startDivB;
  assign divNum   = strobe.startDivA ? product : divQuo;
  assign divDen   = strobe.startDivA ? linkCap : DIV_W'(SCALE);

  tu_restoring_div #(.W(DIV_W)) u_div (
    .clk       (clk),
    .rstN      (rstN),
    .start     (divStart),
    .dividend  (divNum),
    .divisor   (divDen),
    .quotient  (divQuo),
    .remainder (divRem),
    .done      (divDone)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixR   <= '0;
      depthR <= '0;
      is422R <= 1'b0;
      lanesR <= '0;
      rateR  <= '0;
      tuR    <= '0;
      symR   <= '0;
      fracR  <= '0;
    end else begin
      if (strobe.latchIn) begin
        pixR   <= pixClkKhz;
        depthR <= colorDepth;
        is422R <= is422;
        lanesR <= laneCount;
        rateR  <= linkRateMhz;
        tuR    <= TU_W'(TU_FIRST);
      end else if (strobe.stepTu) begin
        tuR <= tuR + TU_W'(TU_STEP);
      end
      if (strobe.captureSym) begin
        symR  <= divQuo;
        fracR <= divRem[FRAC_W-1:0];
      end
    end
  end

  logic symBigEnough;
  logic headroomOk;
  logic fracOk;

  assign symBigEnough = symR > DIV_W'(1);
  assign headroomOk   = ({1'b0, symR} + (DIV_W+1)'(4)) <= (DIV_W+1)'(tuR);
  assign fracOk       = (fracR >= FRAC_W'(FRAC_LO)) && (fracR <= FRAC_W'(FRAC_HI));

  assign status.divDone = divDone;
  assign status.candOk  = symBigEnough && headroomOk && fracOk;
  assign status.tuLast  = tuR >= TU_W'(TU_LAST);
  assign status.argZero = (lanesR == '0) || (rateR == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      done      <= 1'b0;
      searchErr <= 1'b0;
      cfgWord   <= '0;
    end else if (strobe.commitOk) begin
      done      <= 1'b1;
      searchErr <= 1'b0;
      cfgWord   <= '0;
      cfgWord[7:0]                <= symR[7:0];
      cfgWord[TU_LSB +: 8]        <= 8'(tuR);
      cfgWord[RST_BIT]            <= 1'b1;
    end else if (strobe.commitErr) begin
      done      <= 1'b1;
      searchErr <= 1'b1;
      cfgWord   <= '0;
    end else if (strobe.latchIn) begin
      done      <= 1'b0;
      searchErr <= 1'b0;
      cfgWord   <= '0;
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/tu_search_ctrl.sv
module tu_search_ctrl
  import tu_search_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  dpStatus_t   status,
  output ctrlStrobe_t strobe,
  output logic        busy
);
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ARGS,
    ST_DIV_A,
    ST_DIV_B,
    ST_JUDGE
  } state_t;

  state_t state;
  state_t stateNext;

  always_comb begin
    stateNext = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.latchIn = 1'b1;
          stateNext      = ST_ARGS;
        end
      end
      ST_ARGS: begin
        if (status.argZero) begin
          strobe.commitErr = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strobe.startDivA = 1'b1;
          stateNext        = ST_DIV_A;
        end
      end
      ST_DIV_A: begin
        if (status.divDone) begin
          strobe.startDivB = 1'b1;
          stateNext        = ST_DIV_B;
        end
      end
      ST_DIV_B: begin
        if (status.divDone) begin
          strobe.captureSym = 1'b1;
          stateNext         = ST_JUDGE;
        end
      end
      ST_JUDGE: begin
        if (status.candOk) begin
          strobe.commitOk = 1'b1;
          stateNext       = ST_IDLE;
        end else if (status.tuLast) begin
          strobe.commitErr = 1'b1;
          stateNext        = ST_IDLE;
        end else begin
          strobe.stepTu = 1'b1;
          stateNext     = ST_ARGS;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/tu_fill_search.sv
module tu_fill_search
  import tu_search_pkg::*;
#(
  parameter int PIX_W   = 20,
  parameter int DEPTH_W = 5,
  parameter int LANE_W  = 3,
  parameter int RATE_W  = 12,
  parameter int WORD_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PIX_W-1:0]   pixClkKhz,
  input  logic [DEPTH_W-1:0] colorDepth,
  input  logic               is422,
  input  logic [LANE_W-1:0]  laneCount,
  input  logic [RATE_W-1:0]  linkRateMhz,
  output logic               busy,
  output logic               done,
  output logic               searchErr,
  output logic [WORD_W-1:0]  cfgWord
);
  ctrlStrobe_t strobe;
  dpStatus_t   status;

  tu_search_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .status (status),
    .strobe (strobe),
    .busy   (busy)
  );

  tu_search_dp #(
    .PIX_W   (PIX_W),
    .DEPTH_W (DEPTH_W),
    .LANE_W  (LANE_W),
    .RATE_W  (RATE_W),
    .WORD_W  (WORD_W)
  ) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .pixClkKhz   (pixClkKhz),
    .colorDepth  (colorDepth),
    .is422       (is422),
    .laneCount   (laneCount),
    .linkRateMhz (linkRateMhz),
    .status      (status),
    .done        (done),
    .searchErr   (searchErr),
    .cfgWord     (cfgWord)
  );

endmodule

// File: rtl/tu_search_chk.sv
module tu_search_chk #(
  parameter int LANE_W = 3,
  parameter int RATE_W = 12,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [LANE_W-1:0] laneCount,
  input logic [RATE_W-1:0] linkRateMhz,
  input logic              busy,
  input logic              done,
  input logic              searchErr,
  input logic [WORD_W-1:0] cfgWord
);
  logic [7:0] tuF;
  logic [7:0] symF;
  assign tuF  = cfgWord[15:8];
  assign symF = cfgWord[7:0];

  // R9: one-cycle done, idle while posting
  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R9: results hold between posts and accepted starts
  assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!done && !$past(start)) |-> ($stable(cfgWord) && $stable(searchErr)));

  // R7: an error posts an all-zero word
  assert_err_word_R7: assert property (@(posedge clk) disable iff (!rstN)
    (done && searchErr) |-> (cfgWord == '0));

  // R3, R5: a success posts a legal packed word
  assert_ok_word_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !searchErr) |-> (cfgWord[16] && (cfgWord[WORD_W-1:17] == '0) &&
      (tuF >= 8'd32) && (tuF <= 8'd64) && !tuF[0] &&
      (symF >= 8'd2) && ({1'b0, symF} + 9'd4 <= {1'b0, tuF})));

  // R8: zero argument errors after two edges
  assert_zero_arg_R8: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy && ((laneCount == '0) || (linkRateMhz == '0)))
      |=> ##1 (done && searchErr));

endmodule

bind tu_fill_search tu_search_chk #(
  .LANE_W (LANE_W),
  .RATE_W (RATE_W),
  .WORD_W (WORD_W)
) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .start       (start),
  .laneCount   (laneCount),
  .linkRateMhz (linkRateMhz),
  .busy        (busy),
  .done        (done),
  .searchErr   (searchErr),
  .cfgWord     (cfgWord)
);

// File: tb/tu_fill_search_bench.sv
module tu_fill_search_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [19:0] pixClkKhz = '0;
  logic [4:0]  colorDepth = '0;
  logic        is422 = 1'b0;
  logic [2:0]  laneCount = '0;
  logic [11:0] linkRateMhz = '0;
  logic        busy;
  logic        done;
  logic        searchErr;
  logic [31:0] cfgWord;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  tu_fill_search u_tu_fill_search (
    .clk         (clk),
    .rstN        (rstN),
    .start       (start),
    .pixClkKhz   (pixClkKhz),
    .colorDepth  (colorDepth),
    .is422       (is422),
    .laneCount   (laneCount),
    .linkRateMhz (linkRateMhz),
    .busy        (busy),
    .done        (done),
    .searchErr   (searchErr),
    .cfgWord     (cfgWord)
  );

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Independent model of the search rules
  function automatic void model(input longint pix, input longint depth,
                                input bit s422, input longint lanes,
                                input longint rate, output logic [31:0] w,
                                output bit e);
    longint bppV, q, s, r;
    w = '0;
    e = 1'b1;
    if (lanes == 0 || rate == 0) return;
    bppV = s422 ? 2 * depth : 3 * depth;
    for (longint tu = 32; tu <= 64; tu += 2) begin
      q = (tu * pix * bppV) / (lanes * rate * 8);
      s = q / 1000;
      r = q % 1000;
      if (s > 1 && (tu - s) >= 4 && r >= 100 && r <= 850) begin
        w = 32'(s) | (32'(tu) << 8) | (32'd1 << 16);
        e = 1'b0;
        return;
      end
    end
  endfunction

  task automatic setArgs(input int pix, input int depth, input bit s422,
                         input int lanes, input int rate);
    pixClkKhz   = 20'(pix);
    colorDepth  = 5'(depth);
    is422       = s422;
    laneCount   = 3'(lanes);
    linkRateMhz = 12'(rate);
  endtask

  // Pulse start, wait for done; returns word, error and latency in cycles
  task automatic runJob(input int pix, input int depth, input bit s422,
                        input int lanes, input int rate, input string tag,
                        output logic [31:0] w, output bit e, output int lat);
    bit seen = 1'b0;
    @(negedge clk);
    setArgs(pix, depth, s422, lanes, rate);
    start = 1'b1;
    lat = 0;
    for (int k = 1; k <= 5000 && !seen; k++) begin
      @(negedge clk);
      start = 1'b0;
      if (done) begin
        seen = 1'b1;
        lat = k;
      end
    end
    w = cfgWord;
    e = searchErr;
    check(seen, {tag, " done seen"}, 32'(seen), 32'd1);
    check(!busy, {"R9 busy low at done ", tag}, 32'(busy), 32'd0);
    @(negedge clk);
    check(!done, {"R9 done one cycle ", tag}, 32'(done), 32'd0);
  endtask

  task automatic jobVsModel(input int pix, input int depth, input bit s422,
                            input int lanes, input int rate, input string tag);
    logic [31:0] w, ew;
    bit e, ee;
    int lat;
    model(pix, depth, s422, lanes, rate, ew, ee);
    runJob(pix, depth, s422, lanes, rate, tag, w, e, lat);
    check(w == ew, {tag, " word"}, w, ew);
    check(e == ee, {tag, " err"}, 32'(e), 32'(ee));
  endtask

  task automatic testReset();
    check(!busy && !done && !searchErr, "R11 reset flags",
          {29'd0, busy, done, searchErr}, 32'd0);
    check(cfgWord == '0, "R11 reset word", cfgWord, 32'd0);
  endtask

  task automatic testMain();
    logic [31:0] w;
    bit e;
    int lat;
    // R1 R2 R3 R4: 4:4:4 depth 8, 4 lanes, 270 MHz: q=13200 -> sym 13 frac 200 at TU 32
    runJob(148500, 8, 1'b0, 4, 270, "R3", w, e, lat);
    check(w == 32'h0001_200D && !e, "R3 R2 R4 known word", w, 32'h0001_200D);
    jobVsModel(74250, 8, 1'b1, 2, 270, "R1 422");
    jobVsModel(74250, 8, 1'b0, 2, 270, "R1 444");
    jobVsModel(25175, 10, 1'b0, 1, 162, "R2 one lane");
    jobVsModel(594000, 8, 1'b0, 4, 540, "R4 high rate");
    jobVsModel(108000, 12, 1'b1, 2, 162, "R1 422 deep");
  endtask

  task automatic testFraction();
    logic [31:0] w;
    bit e;
    int lat;
    runJob(65813, 8, 1'b0, 4, 270, "R6 frac 850", w, e, lat);
    check(w == 32'h0001_2005, "R6 frac 850 accepted", w, 32'h0001_2005);
    runJob(65824, 8, 1'b0, 4, 270, "R6 frac 851", w, e, lat);
    check(w == 32'h0001_2206, "R6 frac 851 rejected, R4 step", w, 32'h0001_2206);
    jobVsModel(57375, 8, 1'b0, 4, 270, "R6 frac 100");
    jobVsModel(57364, 8, 1'b0, 4, 270, "R6 frac 99");
  endtask

  task automatic testExhaust();
    logic [31:0] w;
    bit e;
    int lat;
    runJob(10000, 8, 1'b0, 4, 270, "R5 R7 small sym", w, e, lat);
    check(e && w == '0, "R5 R7 small sym error", {w[30:0], e}, 32'd1);
    runJob(600000, 16, 1'b0, 1, 162, "R5 R7 sym over TU", w, e, lat);
    check(e && w == '0, "R5 R7 sym over TU error", {w[30:0], e}, 32'd1);
  endtask

  task automatic testZeroArgs();
    logic [31:0] w;
    bit e;
    int lat;
    runJob(148500, 8, 1'b0, 0, 270, "R8 zero lanes", w, e, lat);
    check(e && w == '0, "R8 zero lanes error", {w[30:0], e}, 32'd1);
    check(lat == 2, "R8 zero lanes latency", 32'(lat), 32'd2);
    runJob(148500, 8, 1'b0, 4, 0, "R8 zero rate", w, e, lat);
    check(e && w == '0, "R8 zero rate error", {w[30:0], e}, 32'd1);
    check(lat == 2, "R8 zero rate latency", 32'(lat), 32'd2);
  endtask

  task automatic testHold();
    logic [31:0] w;
    bit e;
    int lat;
    int extraDone = 0;
    bit moved = 1'b0;
    runJob(148500, 8, 1'b0, 4, 270, "R9 hold", w, e, lat);
    setArgs(5000, 3, 1'b1, 0, 0);
    for (int k = 0; k < 60; k++) begin
      @(negedge clk);
      if (done) extraDone++;
      if (cfgWord != w || searchErr != e) moved = 1'b1;
    end
    check(!moved, "R9 word holds without start", cfgWord, w);
    check(extraDone == 0, "R9 no stray done", 32'(extraDone), 32'd0);
  endtask

  task automatic testBusyStart();
    logic [31:0] ew;
    bit ee;
    int doneCount = 0;
    bit seen = 1'b0;
    model(148500, 8, 1'b0, 4, 270, ew, ee);
    @(negedge clk);
    setArgs(148500, 8, 1'b0, 4, 270);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (10) @(negedge clk);
    setArgs(30000, 6, 1'b1, 0, 162);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 3000; k++) begin
      if (done) begin
        doneCount++;
        if (!seen) begin
          seen = 1'b1;
          check(cfgWord == ew, "R10 word from first job", cfgWord, ew);
          check(searchErr == ee, "R10 err from first job", 32'(searchErr), 32'(ee));
        end
      end
      @(negedge clk);
    end
    check(doneCount == 1, "R10 single done", 32'(doneCount), 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    testMain();
    testFraction();
    testExhaust();
    testZeroArgs();
    testHold();
    testBusyStart();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule